// File: doc/BRIEF.md
# Auto-Indexed Wake-Up Filter Register Bank

This block holds the configuration for four wake-up frame filters in eight 32-bit storage words. All eight words sit behind a single register address. An internal 3-bit index selects the word that the next access reaches. Every accepted write stores its word at that index and then moves the index forward by one. Every read returns the word at the index and also moves it forward. Software can therefore load the whole bank, or dump it, by touching the same address eight times in a row. The index is reported on its own status output, so software can see where the sequence stands.

Besides the storage, the block splits the words into fields that the filters use. Words 0 to 3 carry the byte-select masks of filters 0 to 3. Word 4 carries the four command nibbles. Word 5 carries the four byte offsets. Words 6 and 7 carry the four 16-bit CRC values. The bus side is a plain strobe interface: a write strobe with byte enables, a read strobe, and a read data bus that always shows the word at the current index.

Top module: `wkf_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears all eight words to zero and sets the index (`stat_ptr`) to 0.
- R2: A write strobe with all four byte enables set (`bank_be` = 4'b1111) and no read strobe stores `bank_wdata` into the word at the index. The index then advances by one.
- R3: The index is 3 bits wide and wraps from 7 to 0. A ninth consecutive write therefore overwrites word 0.
- R4: A write strobe with any byte enable clear changes no word and leaves the index where it was.
- R5: `bank_rdata` always shows the word at the current index. A read strobe advances the index by one, so successive reads return the words in the same order that writes fill them.
- R6: `stat_ptr` always equals the index that the next access will use.
- R7: A full write and a read strobe in the same cycle do the following: during that cycle `bank_rdata` shows the old word, the new word is stored, and the index advances by exactly one.
- R8: Filter n's 31-bit byte mask (`flt_mask[31n+30:31n]`) is bits 30:0 of word n, for n = 0..3. Bit 31 of those words does not reach any filter.
- R9: Filter n's 4-bit command (`flt_cmd[4n+3:4n]`) is bits 8n+3:8n of word 4. Bits 8n+7:8n+4 are reserved and reach no filter.
- R10: Filter n's 8-bit offset (`flt_ofs[8n+7:8n]`) is bits 8n+7:8n of word 5.
- R11: The 16-bit CRC values of filters 0 and 1 come from word 6, and those of filters 2 and 3 come from word 7. In each word the lower-numbered filter takes bits 15:0, and `flt_crc[16n+15:16n]` belongs to filter n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_wr | input | 1 | Write strobe for the bank address |
| bank_rd | input | 1 | Read strobe for the bank address |
| bank_be | input | 4 | Byte enables of the write |
| bank_wdata | input | 32 | Write data |
| bank_rdata | output | 32 | Word at the current index |
| stat_ptr | output | 3 | Current index (status field) |
| flt_mask | output | 124 | Four 31-bit byte masks, filter 0 in the low bits |
| flt_cmd | output | 16 | Four 4-bit commands, filter 0 in the low bits |
| flt_ofs | output | 32 | Four 8-bit offsets, filter 0 in the low bits |
| flt_crc | output | 64 | Four 16-bit CRC values, filter 0 in the low bits |

## Verification
The assertions check on every cycle how the index moves. It steps by exactly one on an accepted access, and it holds on an idle cycle or a partial write. They also check that a full write lands in the word it addressed and that reset leaves the index at zero. Only the bench's scenarios can show the rest. That covers the full fill and read-back order, the wrap into word 0, the fact that every partial byte-enable pattern leaves the stored contents untouched, the old-data read when a read and a write meet, and the placement of every field in the filter outputs.

// File: rtl/wkf_pkg.sv
// Package: shared sizes for the wake-up filter register bank.
// Assumes the word count (masks + command + offset + CRC words) is a power of two.
package wkf_pkg;
    localparam int NUM_FLT  = 4;                         // number of wake-up filters
    localparam int WORD_W   = 32;                        // storage word width
    localparam int BE_W     = WORD_W / 8;                // byte enables per word
    localparam int MASK_W   = WORD_W - 1;                // usable mask bits per filter
    localparam int CMD_W    = 4;                         // command bits per filter
    localparam int LANE_W   = 8;                         // byte lane per command/offset
    localparam int CRC_W    = 16;                        // CRC bits per filter
    localparam int CMD_IDX  = NUM_FLT;                   // word holding commands
    localparam int OFS_IDX  = NUM_FLT + 1;               // word holding offsets
    localparam int CRC_IDX  = NUM_FLT + 2;               // first CRC word
    localparam int CRC_PER_WORD = WORD_W / CRC_W;        // CRC values per word
    localparam int DEPTH    = CRC_IDX + NUM_FLT / CRC_PER_WORD;
    localparam int PTR_W    = $clog2(DEPTH);

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/wkf_ptr.sv
// Module: wkf_ptr
// Holds the shared access index of the bank. It advances by one on every
// accepted access and wraps from DEPTH-1 to 0.
// Assumes: step is a single-cycle qualified access pulse; reset is synchronous, active low.
module wkf_ptr
    import wkf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output ptr_t ptr
);
    localparam ptr_t LAST = ptr_t'(DEPTH - 1);

    // Index register: clear on reset, wrap at the last word, otherwise increment on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (step) begin
            if (ptr == LAST) ptr <= '0;
            else             ptr <= ptr + ptr_t'(1);
        end
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ptr == LAST) |=> (ptr == '0)); // R3

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ptr)); // R4
endmodule

// File: rtl/wkf_store.sv
// Module: wkf_store
// Register array for the bank. Writes one full word at the given index when
// wr_en is high, and exposes every word as one flat bus for field breakout
// and the read mux.
// Assumes: wr_en is already qualified to full-word writes.
module wkf_store
    import wkf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  ptr_t                    wr_idx,
    input  word_t                   wr_data,
    output logic [DEPTH*WORD_W-1:0] words
);
    word_t mem [DEPTH];

    // Storage words: all cleared on reset, the indexed word loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_flat
            // Flatten word g into its slot of the output bus.
            always_comb words[g*WORD_W +: WORD_W] = mem[g];
        end
    endgenerate

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_data))); // R2
endmodule

// File: rtl/wkf_unpack.sv
// Module: wkf_unpack
// Splits the flat word bus into per-filter fields. Words 0..NUM_FLT-1 hold
// the masks, word CMD_IDX holds one command per byte lane, word OFS_IDX holds
// one offset per byte lane, and the CRC words pack two values each with the
// lower filter in the low half.
// Assumes: purely combinational; reserved bits are simply not forwarded.
module wkf_unpack
    import wkf_pkg::*;
(
    input  logic [DEPTH*WORD_W-1:0]   words,
    output logic [NUM_FLT*MASK_W-1:0] flt_mask,
    output logic [NUM_FLT*CMD_W-1:0]  flt_cmd,
    output logic [NUM_FLT*LANE_W-1:0] flt_ofs,
    output logic [NUM_FLT*CRC_W-1:0]  flt_crc
);
    localparam int CMD_BASE = CMD_IDX * WORD_W;
    localparam int OFS_BASE = OFS_IDX * WORD_W;
    localparam int CRC_BASE = CRC_IDX * WORD_W;

    genvar n;
    generate
        for (n = 0; n < NUM_FLT; n++) begin : g_flt
            // Mask: low MASK_W bits of word n; the top bit is dropped.
            always_comb flt_mask[n*MASK_W +: MASK_W] = words[n*WORD_W +: MASK_W];
            // Command: low nibble of byte lane n in the command word.
            always_comb flt_cmd[n*CMD_W +: CMD_W] = words[CMD_BASE + n*LANE_W +: CMD_W];
            // Offset: whole byte lane n of the offset word.
            always_comb flt_ofs[n*LANE_W +: LANE_W] = words[OFS_BASE + n*LANE_W +: LANE_W];
            // CRC: consecutive half-words starting at the first CRC word.
            always_comb flt_crc[n*CRC_W +: CRC_W] = words[CRC_BASE + n*CRC_W +: CRC_W];
        end
    endgenerate
endmodule

// File: rtl/wkf_bank.sv
// Module: wkf_bank (top)
// Eight-word wake-up filter configuration bank behind one register address.
// It qualifies the strobes, steps the shared index, reads the indexed word
// and breaks the contents out into per-filter fields.
// Assumes: the strobes are single-cycle pulses from a simple register bus;
// reset is synchronous, active low.
module wkf_bank
    import wkf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bank_wr,
    input  logic                      bank_rd,
    input  logic [BE_W-1:0]           bank_be,
    input  logic [WORD_W-1:0]         bank_wdata,
    output logic [WORD_W-1:0]         bank_rdata,
    output logic [PTR_W-1:0]          stat_ptr,
    output logic [NUM_FLT*MASK_W-1:0] flt_mask,
    output logic [NUM_FLT*CMD_W-1:0]  flt_cmd,
    output logic [NUM_FLT*LANE_W-1:0] flt_ofs,
    output logic [NUM_FLT*CRC_W-1:0]  flt_crc
);
    logic                    wr_full;
    logic                    step;
    ptr_t                    ptr;
    logic [DEPTH*WORD_W-1:0] words;

    // Accept only whole-word writes; any access that is accepted moves the index once.
    always_comb begin
        wr_full = bank_wr && (&bank_be);
        step    = wr_full || bank_rd;
    end

    wkf_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .ptr   (ptr)
    );

    wkf_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_full),
        .wr_idx  (ptr),
        .wr_data (bank_wdata),
        .words   (words)
    );

    wkf_unpack u_unpack (
        .words    (words),
        .flt_mask (flt_mask),
        .flt_cmd  (flt_cmd),
        .flt_ofs  (flt_ofs),
        .flt_crc  (flt_crc)
    );

    // Read path: present the word at the current index.
    always_comb bank_rdata = words[ptr*WORD_W +: WORD_W];

    // Status field: the index of the next access.
    always_comb stat_ptr = ptr;

    AST_RESET_PTR: assert property (@(posedge clk)
        !rst_n |=> (stat_ptr == '0)); // R1

    AST_ACCESS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_wr && bank_be == '1) || bank_rd) |=>
            (stat_ptr == PTR_W'(($past(stat_ptr) + 1) % DEPTH))); // R5

    AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr && bank_be != '1 && !bank_rd) |=>
            ($stable(stat_ptr) && $stable(bank_rdata) && $stable(flt_cmd))); // R4

    AST_BOTH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr && bank_be == '1 && bank_rd) |=>
            (stat_ptr == PTR_W'(($past(stat_ptr) + 1) % DEPTH))); // R7
endmodule

// File: tb/sim_wkf_bank.sv
module sim_wkf_bank;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bank_wr = 1'b0;
    logic         bank_rd = 1'b0;
    logic [3:0]   bank_be = 4'h0;
    logic [31:0]  bank_wdata = '0;
    logic [31:0]  bank_rdata;
    logic [2:0]   stat_ptr;
    logic [123:0] flt_mask;
    logic [15:0]  flt_cmd;
    logic [31:0]  flt_ofs;
    logic [63:0]  flt_crc;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [31:0] exp_mem [DEPTH];
    int          exp_ptr;

    always #2.5 clk = ~clk;   // 200 MHz

    wkf_bank u0 (
        .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_rd(bank_rd),
        .bank_be(bank_be), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
        .stat_ptr(stat_ptr), .flt_mask(flt_mask), .flt_cmd(flt_cmd),
        .flt_ofs(flt_ofs), .flt_crc(flt_crc)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i, input int s);
        return 32'(i) * 32'h0123_4567 + 32'(s) * 32'h9E37_79B9 + 32'h8000_0001;
    endfunction

    // Drive one access at the falling edge; it resolves at the next rising edge.
    task automatic access(input logic wr, input logic rd, input logic [3:0] be,
                          input logic [31:0] d);
        @(negedge clk);
        bank_wr = wr; bank_rd = rd; bank_be = be; bank_wdata = d;
        @(negedge clk);
        bank_wr = 1'b0; bank_rd = 1'b0; bank_be = 4'h0;
        if (wr && be == 4'hF) exp_mem[exp_ptr] = d;
        if ((wr && be == 4'hF) || rd) exp_ptr = (exp_ptr + 1) % DEPTH;
    endtask

    // Compare every field output and the read port with the model.
    task automatic chk_fields(input string tag);
        for (int n = 0; n < 4; n++) begin
            chk("R8", {tag, " mask"}, 128'(flt_mask[n*31 +: 31]), 128'(exp_mem[n][30:0]));
            chk("R9", {tag, " cmd"}, 128'(flt_cmd[n*4 +: 4]), 128'(exp_mem[4][n*8 +: 4]));
            chk("R10", {tag, " ofs"}, 128'(flt_ofs[n*8 +: 8]), 128'(exp_mem[5][n*8 +: 8]));
            chk("R11", {tag, " crc"}, 128'(flt_crc[n*16 +: 16]),
                128'(exp_mem[6 + n/2][(n%2)*16 +: 16]));
        end
        chk("R6", {tag, " ptr"}, 128'(stat_ptr), 128'(exp_ptr));
        chk("R5", {tag, " rdata"}, 128'(bank_rdata), 128'(exp_mem[exp_ptr]));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
        exp_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset ptr", 128'(stat_ptr), 128'(0));
        chk("R1", "reset masks", 128'(flt_mask), 128'(0));
        chk("R1", "reset crc", 128'(flt_crc), 128'(0));

        // R2/R6: fill in several seeds, check index after each write
        for (int s = 0; s < 3; s++) begin
            for (int i = 0; i < DEPTH; i++) begin
                access(1'b1, 1'b0, 4'hF, pat(i, s));
                chk("R2", "write steps ptr", 128'(stat_ptr), 128'(exp_ptr));
            end
            // R3: after eight writes the index is back at 0
            chk("R3", "wrap to 0", 128'(stat_ptr), 128'(0));
            chk_fields("fill");
            // R5: read back in order
            for (int i = 0; i < DEPTH; i++) begin
                chk("R5", "readback", 128'(bank_rdata), 128'(pat(i, s)));
                access(1'b0, 1'b1, 4'h0, '0);
            end
            chk("R5", "read wrap", 128'(stat_ptr), 128'(0));
        end

        // R3: ninth write overwrites word 0
        for (int i = 0; i < DEPTH + 1; i++) access(1'b1, 1'b0, 4'hF, pat(i, 7));
        chk("R3", "ninth write ptr", 128'(stat_ptr), 128'(1));
        chk("R3", "word0 overwritten", 128'(flt_mask[30:0]), 128'(pat(8, 7) & 32'h7FFF_FFFF));

        // R4: every partial byte-enable pattern at every index
        for (int i = 0; i < DEPTH; i++) begin
            for (int b = 0; b < 15; b++) begin
                access(1'b1, 1'b0, 4'(b), 32'hDEAD_0000 + 32'(b));
                chk("R4", "partial ptr", 128'(stat_ptr), 128'(exp_ptr));
                chk("R4", "partial data", 128'(bank_rdata), 128'(exp_mem[exp_ptr]));
            end
            access(1'b0, 1'b1, 4'h0, '0);
        end
        chk_fields("after partial");

        // R7: simultaneous write and read
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            bank_wr = 1'b1; bank_rd = 1'b1; bank_be = 4'hF; bank_wdata = pat(i, 11);
            #1;
            chk("R7", "old data during", 128'(bank_rdata), 128'(exp_mem[exp_ptr]));
            @(negedge clk);
            bank_wr = 1'b0; bank_rd = 1'b0; bank_be = 4'h0;
            exp_mem[exp_ptr] = pat(i, 11);
            exp_ptr = (exp_ptr + 1) % DEPTH;
            chk("R7", "single step", 128'(stat_ptr), 128'(exp_ptr));
        end
        chk_fields("after both");

        // R1: reset mid-contents clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
        exp_ptr = 0;
        chk_fields("post reset R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule